// File: doc/BRIEF.md
# GPIO Bank with Edge and Level Interrupt Detection

This block is one bank of sixteen general-purpose I/O pins behind a small 32-bit register bus. The bus has a write strobe, a read strobe, a byte address and write data. Software picks a drive mode for each pin and sets an output latch. It can read back the synchronised level of every pad, whatever mode the pad is in. The pad side exposes three vectors: output data, output enable and input.

Each pin also has interrupt detection. A per-pin type bit chooses edge or level triggering. There are two independent enables per pin, one for low/falling and one for high/rising, so a single pin can flag on both edges. Detected events latch into a sticky source register, which software clears by writing ones. The bank drives one interrupt line whenever any source bit is pending.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset every register reads zero, every pad output enable is 0, and the bank interrupt is low.
- R2: The mode register at 0x00 holds a 2-bit field for pin n at bits [2n+1:2n], with 0 = input, 1 = push-pull, 2 = open-drain and 3 = quasi-bidirectional. A pin in input mode never enables its output.
- R3: A push-pull pin enables its output and drives bit n of the output latch at 0x08.
- R4: An open-drain pin drives data 0 and enables its output only while its latch bit is 0.
- R5: A quasi-bidirectional pin drives low while its latch bit is 0. While the bit is 1 the pin is released, except that in the one cycle after a 0-to-1 change of the latch it drives high. Rewriting a 1 over a 1 gives no such pulse.
- R6: Bit n at 0x10 returns the level of pad n after a two-flop synchroniser, in every mode. Writes to 0x10 have no effect.
- R7: With type bit n at 0x18 clear (edge mode), enable bit n at 0x1C flags falling edges and enable bit n+16 flags rising edges. With both bits set, the pin flags either edge.
- R8: With type bit n set (level mode), the low enable flags while the synchronised level is 0 and the high enable flags while it is 1. The flag is set again every cycle, so clearing it only sticks once the level has gone.
- R9: Writing 1 to bit n of the source register at 0x20 clears pin n's pending flag, and writing 0 leaves it unchanged. A new detection in the same cycle wins over the clear.
- R10: The bank interrupt is high exactly when any source bit is set, and a source bit can only become set for a pin whose enable for that condition was on.
- R11: Mode, output latch, type and enable read back what was written, limited to implemented bits. Unmapped addresses read zero. Read data appears on the cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered on the read strobe |
| pad_in | input | 16 | Asynchronous pad input levels |
| pad_out | output | 16 | Pad output data |
| pad_oe | output | 16 | Pad output enable |
| bank_irq | output | 1 | Bank interrupt, OR of the pending flags |

## Verification
The checker assumes that write and read strobes land on the clock edge and never overlap with reset release. It also assumes that pad inputs may change at any cycle, because the synchroniser absorbs them. Its properties relate internal register state to pad and interrupt outputs, so they hold for any bus sequence. The directed bench changes pad levels only at falling clock edges. It waits at least four cycles before it reads the source register after a pad change, so every check falls after the synchroniser and the pending flag have settled. It clears all enables and flags at the end of each interrupt scenario, so no flag from one scenario leaks into the next.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam logic [7:0] OFS_MODE  = 8'h00;
    localparam logic [7:0] OFS_DOUT  = 8'h08;
    localparam logic [7:0] OFS_LEVEL = 8'h10;
    localparam logic [7:0] OFS_TYPE  = 8'h18;
    localparam logic [7:0] OFS_EN    = 8'h1C;
    localparam logic [7:0] OFS_SRC   = 8'h20;

    // the rising/high enables start at this bit of the enable register
    localparam int unsigned EN_HI_BASE = 16;

    typedef enum logic [1:0] {
        MODE_IN = 2'd0,
        MODE_PP = 2'd1,
        MODE_OD = 2'd2,
        MODE_QB = 2'd3
    } pin_mode_e;

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] lvl,
    output logic [W-1:0] lvl_prev
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [W-1:0] s3;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = raw;
        st_d.s2 = st_q.s1;
        st_d.s3 = st_q.s2;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lvl      = st_q.s2;
    assign lvl_prev = st_q.s3;
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    input  logic [W-1:0] lvl_prev,
    input  logic [W-1:0] is_level,
    input  logic [W-1:0] en_lo,
    input  logic [W-1:0] en_hi,
    input  logic [W-1:0] clr,
    output logic [W-1:0] pending
);
    typedef struct packed {
        logic [W-1:0] src;
    } det_t;

    det_t st_d, st_q;
    logic [W-1:0] hit;

    for (genvar i = 0; i < W; i++) begin : g_det
        logic rise, fall, lo_cond, hi_cond;
        assign rise    = lvl[i] & ~lvl_prev[i];
        assign fall    = ~lvl[i] & lvl_prev[i];
        assign lo_cond = is_level[i] ? ~lvl[i] : fall;
        assign hi_cond = is_level[i] ?  lvl[i] : rise;
        assign hit[i]  = (en_lo[i] & lo_cond) | (en_hi[i] & hi_cond);
    end

    always_comb begin
        st_d     = st_q;
        st_d.src = (st_q.src & ~clr) | hit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pending = st_q.src;
endmodule

// File: rtl/gpio_pad_drive.sv
module gpio_pad_drive
    import gpio_bank_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [2*W-1:0] mode,
    input  logic [W-1:0]   latch,
    output logic [W-1:0]   pad_out,
    output logic [W-1:0]   pad_oe
);
    typedef struct packed {
        logic [W-1:0] latch_prev;
    } drv_t;

    drv_t st_d, st_q;
    logic [W-1:0] boost;

    always_comb begin
        st_d            = st_q;
        st_d.latch_prev = latch;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign boost = latch & ~st_q.latch_prev;

    for (genvar i = 0; i < W; i++) begin : g_pin
        logic o, e;
        always_comb begin
            o = 1'b0;
            e = 1'b0;
            case (pin_mode_e'(mode[2*i +: 2]))
                MODE_IN: begin o = 1'b0;     e = 1'b0;      end
                MODE_PP: begin o = latch[i]; e = 1'b1;      end
                MODE_OD: begin o = 1'b0;     e = ~latch[i]; end
                MODE_QB: begin
                    if (latch[i]) begin o = 1'b1; e = boost[i]; end
                    else          begin o = 1'b0; e = 1'b1;     end
                end
                default: begin o = 1'b0; e = 1'b0; end
            endcase
        end
        assign pad_out[i] = o;
        assign pad_oe[i]  = e;
    end
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
    import gpio_bank_pkg::*;
#(
    parameter int unsigned PINS   = 16,
    parameter int unsigned ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [PINS-1:0]   pad_in,
    output logic [PINS-1:0]   pad_out,
    output logic [PINS-1:0]   pad_oe,
    output logic              bank_irq
);
    localparam int unsigned MW = 2 * PINS;

    typedef struct packed {
        logic [MW-1:0]   mode;
        logic [PINS-1:0] dout;
        logic [PINS-1:0] itype;
        logic [PINS-1:0] en_lo;
        logic [PINS-1:0] en_hi;
        logic [31:0]     rdata;
    } regs_t;

    regs_t r_d, r_q;

    logic [PINS-1:0] lvl_w, lvl_prev_w, src_w, clr_w;
    logic [MW-1:0]   mode_w;
    logic [PINS-1:0] dout_w, itype_w, ien_lo_w, ien_hi_w;

    logic wr_mode, wr_dout, wr_type, wr_en, wr_src;

    assign wr_mode = bus_wr && (bus_addr == ADDR_W'(OFS_MODE));
    assign wr_dout = bus_wr && (bus_addr == ADDR_W'(OFS_DOUT));
    assign wr_type = bus_wr && (bus_addr == ADDR_W'(OFS_TYPE));
    assign wr_en   = bus_wr && (bus_addr == ADDR_W'(OFS_EN));
    assign wr_src  = bus_wr && (bus_addr == ADDR_W'(OFS_SRC));

    assign clr_w = wr_src ? bus_wdata[PINS-1:0] : '0;

    always_comb begin
        logic [31:0] rd;
        r_d = r_q;
        if (wr_mode) r_d.mode  = bus_wdata[MW-1:0];
        if (wr_dout) r_d.dout  = bus_wdata[PINS-1:0];
        if (wr_type) r_d.itype = bus_wdata[PINS-1:0];
        if (wr_en) begin
            r_d.en_lo = bus_wdata[PINS-1:0];
            r_d.en_hi = bus_wdata[EN_HI_BASE +: PINS];
        end
        rd = '0;
        case (bus_addr)
            ADDR_W'(OFS_MODE):  rd[MW-1:0]   = r_q.mode;
            ADDR_W'(OFS_DOUT):  rd[PINS-1:0] = r_q.dout;
            ADDR_W'(OFS_LEVEL): rd[PINS-1:0] = lvl_w;
            ADDR_W'(OFS_TYPE):  rd[PINS-1:0] = r_q.itype;
            ADDR_W'(OFS_EN): begin
                rd[PINS-1:0]             = r_q.en_lo;
                rd[EN_HI_BASE +: PINS]   = r_q.en_hi;
            end
            ADDR_W'(OFS_SRC):   rd[PINS-1:0] = src_w;
            default:            rd = '0;
        endcase
        if (bus_rd) r_d.rdata = rd;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    gpio_in_sync #(.W(PINS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw      (pad_in),
        .lvl      (lvl_w),
        .lvl_prev (lvl_prev_w)
    );

    gpio_irq_detect #(.W(PINS)) u_det (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl      (lvl_w),
        .lvl_prev (lvl_prev_w),
        .is_level (r_q.itype),
        .en_lo    (r_q.en_lo),
        .en_hi    (r_q.en_hi),
        .clr      (clr_w),
        .pending  (src_w)
    );

    gpio_pad_drive #(.W(PINS)) u_drv (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (r_q.mode),
        .latch   (r_q.dout),
        .pad_out (pad_out),
        .pad_oe  (pad_oe)
    );

    assign mode_w    = r_q.mode;
    assign dout_w    = r_q.dout;
    assign itype_w   = r_q.itype;
    assign ien_lo_w  = r_q.en_lo;
    assign ien_hi_w  = r_q.en_hi;
    assign bus_rdata = r_q.rdata;
    assign bank_irq  = |src_w;
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk #(
    parameter int unsigned PINS   = 16,
    parameter int unsigned ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [PINS-1:0]   pad_out,
    input logic [PINS-1:0]   pad_oe,
    input logic              bank_irq,
    input logic [2*PINS-1:0] mode_w,
    input logic [PINS-1:0]   dout_w,
    input logic [PINS-1:0]   itype_w,
    input logic [PINS-1:0]   ien_lo_w,
    input logic [PINS-1:0]   ien_hi_w,
    input logic [PINS-1:0]   src_w,
    input logic [PINS-1:0]   lvl_w,
    input logic [PINS-1:0]   lvl_prev_w
);
    logic [PINS-1:0] m_in, m_pp, m_od, m_qb;

    always_comb begin
        for (int i = 0; i < PINS; i++) begin
            m_in[i] = (mode_w[2*i +: 2] == 2'd0);
            m_pp[i] = (mode_w[2*i +: 2] == 2'd1);
            m_od[i] = (mode_w[2*i +: 2] == 2'd2);
            m_qb[i] = (mode_w[2*i +: 2] == 2'd3);
        end
    end

    assert_input_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & m_in) == '0);

    assert_pushpull_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((m_pp & ~pad_oe) == '0) && ((m_pp & (pad_out ^ dout_w)) == '0));

    assert_opendrain_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((m_od & pad_out) == '0) && ((m_od & (pad_oe ^ ~dout_w)) == '0));

    assert_quasi_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((m_qb & ~dout_w & ~(pad_oe & ~pad_out)) == '0));

    assert_edge_needs_change_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((src_w & ~$past(src_w) & ~$past(itype_w)
                   & ~($past(lvl_w) ^ $past(lvl_prev_w))) == '0));

    assert_no_silent_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == ADDR_W'(8'h20)) |=> ((src_w & $past(src_w)) == $past(src_w)));

    assert_flag_needs_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((src_w & ~$past(src_w) & ~($past(ien_lo_w) | $past(ien_hi_w))) == '0));

    assert_irq_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bank_irq) |-> ($past(ien_lo_w) | $past(ien_hi_w)) != '0);
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.PINS(PINS), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .pad_out    (pad_out),
    .pad_oe     (pad_oe),
    .bank_irq   (bank_irq),
    .mode_w     (mode_w),
    .dout_w     (dout_w),
    .itype_w    (itype_w),
    .ien_lo_w   (ien_lo_w),
    .ien_hi_w   (ien_hi_w),
    .src_w      (src_w),
    .lvl_w      (lvl_w),
    .lvl_prev_w (lvl_prev_w)
);

// File: tb/gpio_irq_bank_test.sv
module gpio_irq_bank_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] pad_in = '0;
    logic [15:0] pad_out;
    logic [15:0] pad_oe;
    logic        bank_irq;

    int total = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    gpio_irq_bank uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .bank_irq(bank_irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1 oe", {16'h0, pad_oe}, 32'h0);
        check("R1 irq", {31'h0, bank_irq}, 32'h0);
        bus_read(8'h00, v); check("R1 mode", v, 32'h0);
        bus_read(8'h08, v); check("R1 dout", v, 32'h0);
        bus_read(8'h18, v); check("R1 type", v, 32'h0);
        bus_read(8'h1C, v); check("R1 enable", v, 32'h0);
        bus_read(8'h20, v); check("R1 source", v, 32'h0);
    endtask

    task automatic t_modes();
        bus_write(8'h08, 32'h0000_0006);
        bus_write(8'h00, 32'h0000_0064);
        check("R2 R3 R4 oe latch=6", {16'h0, pad_oe}, 32'h0000_000A);
        check("R3 R4 out latch=6", {16'h0, pad_out}, 32'h0000_0002);
        bus_write(8'h08, 32'h0000_0000);
        check("R2 R3 R4 oe latch=0", {16'h0, pad_oe}, 32'h0000_000E);
        check("R3 R4 out latch=0", {16'h0, pad_out}, 32'h0000_0000);
        bus_write(8'h00, 32'h0);
        check("R2 all input", {16'h0, pad_oe}, 32'h0);
    endtask

    task automatic t_quasi();
        bus_write(8'h00, 32'h0000_0C00);
        check("R5 quasi low oe", {16'h0, pad_oe}, 32'h0000_0020);
        check("R5 quasi low out", {16'h0, pad_out}, 32'h0000_0000);
        bus_write(8'h08, 32'h0000_0020);
        check("R5 boost oe", {16'h0, pad_oe}, 32'h0000_0020);
        check("R5 boost out", {16'h0, pad_out}, 32'h0000_0020);
        @(negedge clk);
        check("R5 released oe", {16'h0, pad_oe}, 32'h0000_0000);
        bus_write(8'h08, 32'h0000_0020);
        check("R5 no boost on 1->1", {16'h0, pad_oe}, 32'h0000_0000);
        bus_write(8'h08, 32'h0);
        bus_write(8'h00, 32'h0);
    endtask

    task automatic t_readback();
        logic [31:0] v;
        bus_write(8'h00, 32'hA5A5_5A5A); bus_read(8'h00, v); check("R11 mode", v, 32'hA5A5_5A5A);
        bus_write(8'h08, 32'hFFFF_1234); bus_read(8'h08, v); check("R11 dout", v, 32'h0000_1234);
        bus_write(8'h18, 32'h0003_8001); bus_read(8'h18, v); check("R11 type", v, 32'h0000_8001);
        bus_write(8'h1C, 32'h1234_5678); bus_read(8'h1C, v); check("R11 enable", v, 32'h1234_5678);
        bus_write(8'h1C, 32'h0);
        bus_write(8'h18, 32'h0);
        bus_write(8'h20, 32'hFFFF_FFFF);
        bus_read(8'h04, v); check("R11 unmapped", v, 32'h0);
        pad_in = 16'hBEEF;
        settle();
        bus_read(8'h10, v); check("R6 level with mixed modes", v, 32'h0000_BEEF);
        bus_write(8'h10, 32'h0000_FFFF);
        bus_read(8'h10, v); check("R6 write ignored", v, 32'h0000_BEEF);
        bus_write(8'h00, 32'h0);
        bus_write(8'h08, 32'h0);
        pad_in = 16'h0;
        settle();
        bus_read(8'h10, v); check("R6 level zero", v, 32'h0);
    endtask

    task automatic t_edge();
        logic [31:0] v;
        bus_write(8'h1C, 32'h0006_0005);
        pad_in = 16'h0007;
        settle();
        bus_read(8'h20, v); check("R7 rising flags", v, 32'h0000_0006);
        check("R10 irq high", {31'h0, bank_irq}, 32'h1);
        bus_write(8'h20, 32'h0);
        bus_read(8'h20, v); check("R9 write zero keeps", v, 32'h0000_0006);
        bus_write(8'h20, 32'h0000_0006);
        bus_read(8'h20, v); check("R9 W1C clears, R7 no refire", v, 32'h0);
        check("R10 irq low", {31'h0, bank_irq}, 32'h0);
        pad_in = 16'h0000;
        settle();
        bus_read(8'h20, v); check("R7 falling flags", v, 32'h0000_0005);
        bus_write(8'h1C, 32'h0);
        bus_write(8'h20, 32'h0000_FFFF);
        bus_read(8'h20, v); check("R9 clear all", v, 32'h0);
    endtask

    task automatic t_level();
        logic [31:0] v;
        pad_in = 16'h0010;
        settle();
        bus_write(8'h18, 32'h0000_0018);
        bus_write(8'h1C, 32'h0008_0010);
        settle();
        bus_read(8'h20, v); check("R8 levels absent", v, 32'h0);
        pad_in = 16'h0008;
        settle();
        bus_read(8'h20, v); check("R8 levels present", v, 32'h0000_0018);
        bus_write(8'h20, 32'h0000_0018);
        bus_read(8'h20, v); check("R8 clear while present", v, 32'h0000_0018);
        pad_in = 16'h0010;
        settle();
        bus_write(8'h20, 32'h0000_0018);
        bus_read(8'h20, v); check("R8 clear after removal", v, 32'h0);
        check("R10 irq low after clear", {31'h0, bank_irq}, 32'h0);
        bus_write(8'h1C, 32'h0);
        bus_write(8'h18, 32'h0);
        pad_in = 16'h0;
        settle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_modes();
        t_quasi();
        t_readback();
        t_edge();
        t_level();
        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule